// File: doc/BRIEF.md
# PCI Initiator Master-Abort Sequencer

This block is the bus-side control of a PCI initiator for one transaction at a time. When the request logic asks to start a transaction, the block drives FRAME low for the address phase. From the next cycle it holds IRDY low for the data phases. It also watches the sampled DEVSEL line. If no target claims the transaction within a fixed number of clocks, the block declares a master abort. It then releases FRAME and IRDY in the order the bus protocol requires.

That order depends on the state of FRAME when the abort is found:
- If FRAME is still low, FRAME goes high first while IRDY stays low, and IRDY goes high one cycle later.
- If the last data phase has already started, only IRDY remains to be released, and it goes high on the next cycle.

When a target does claim the transaction, the block ends it normally. The request side marks the last data phase, and the block raises FRAME. IRDY is then released once the target signals TRDY or STOP.

A sticky flag records every master abort until software clears it with a write-one-to-clear strobe. A one-cycle done pulse marks the end of each transaction. Address and data paths and arbitration are outside this block.

Top module: `pci_mabort_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, frame_n_o and irdy_n_o are 1 (released, active-low) and done_o and abort_o are 0.
- R2: A start_i seen at a clock edge while idle drives frame_n_o to 0 in the next cycle (the address phase), with irdy_n_o still 1. irdy_n_o goes to 0 one cycle later.
- R3: start_i is ignored while a transaction is in progress.
- R4: If devsel_n_i is 1 in all TIMEOUT_CLKS (default 5) cycles beginning with the address-phase cycle, the last of those cycles is the detection cycle. In that case abort_o reads 1 from the following cycle.
- R5: If frame_n_o is 0 in the detection cycle, the next cycle has frame_n_o 1 and irdy_n_o 0, and the cycle after that has irdy_n_o 1.
- R6: If frame_n_o is already 1 in the detection cycle, irdy_n_o is 1 in the next cycle.
- R7: A 0 on devsel_n_i in any cycle of the timeout window cancels the timeout for the rest of that transaction.
- R8: last_i at 1 during a data phase with frame_n_o at 0 makes frame_n_o 1 in the next cycle, with irdy_n_o held at 0.
- R9: In the last data phase (frame_n_o 1, irdy_n_o 0), a cycle with devsel_n_i 0 and either trdy_n_i 0 or stop_n_i 0 makes irdy_n_o 1 in the next cycle.
- R10: During a data phase with frame_n_o at 0, a cycle with devsel_n_i 0 and stop_n_i 0 makes frame_n_o 1 in the next cycle (target disconnect).
- R11: done_o is 1 for exactly one cycle, the first cycle in which irdy_n_o is back at 1 after a transaction, whether the transaction ended normally or by abort.
- R12: abort_o stays 1 until a cycle with abort_clr_i at 1, after which it reads 0. When a new abort and the clear fall in the same cycle, the abort wins.
- R13: Every accepted start gives the new transaction a full TIMEOUT_CLKS window, whatever the previous transaction left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a transaction |
| last_i | input | 1 | Current data phase is the last one |
| devsel_n_i | input | 1 | Sampled DEVSEL, active-low |
| trdy_n_i | input | 1 | Sampled TRDY, active-low |
| stop_n_i | input | 1 | Sampled STOP, active-low |
| abort_clr_i | input | 1 | Write-one-to-clear strobe for the abort flag |
| frame_n_o | output | 1 | FRAME drive, active-low |
| irdy_n_o | output | 1 | IRDY drive, active-low |
| abort_o | output | 1 | Sticky master-abort flag |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
All outputs are registered, so every output answers an input seen at a clock edge one cycle later:
- frame_n_o falls one cycle after start_i, and irdy_n_o falls one cycle after that.
- With the default window, the abort is detected in the fifth cycle counted from the address phase. abort_o and the first release step follow one cycle after detection.
- When FRAME is still low at detection, IRDY is released one further cycle later.

The bench drives inputs and samples outputs on the falling clock edge. A behavioural model, updated on the rising edge, is compared with every output on every cycle. Directed checks look at the exact cycle counted above for each release step, for the done pulse and for changes of the flag.

// File: rtl/msq_pkg.sv
package msq_pkg;

  // Bus phase of the sequencer
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DATA  = 3'd2,
    PH_LAST  = 3'd3,
    PH_DRAIN = 3'd4
  } msq_phase_e;

  // Registered pin drive bundle
  typedef struct packed {
    logic frame_n;
    logic irdy_n;
    logic done;
  } msq_drive_t;

  function automatic msq_drive_t msq_drive_of(input msq_phase_e ph, input logic ending);
    msq_drive_t d;
    d.frame_n = !(ph == PH_ADDR || ph == PH_DATA);
    d.irdy_n  = !(ph == PH_DATA || ph == PH_LAST || ph == PH_DRAIN);
    d.done    = ending;
    return d;
  endfunction

endpackage

// File: rtl/msq_claim_timer.sv
module msq_claim_timer #(
  parameter int unsigned TIMEOUT_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic devsel_n_i,
  output logic expire_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CNT_W-1:0] FINAL_SLOT = CNT_W'(TIMEOUT_CLKS - 1);

  logic             armed_q;
  logic [CNT_W-1:0] seen_q;

  // Expiry: still unclaimed in the final window slot
  assign expire_o = armed_q & devsel_n_i & (seen_q == FINAL_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      seen_q  <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      seen_q  <= '0;
    end else if (armed_q) begin
      if (!devsel_n_i || expire_o) begin
        armed_q <= 1'b0;
      end else begin
        seen_q <= seen_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/msq_phase_fsm.sv
module msq_phase_fsm
  import msq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic last_i,
  input  logic devsel_n_i,
  input  logic trdy_n_i,
  input  logic stop_n_i,
  input  logic expire_i,
  output logic accept_o,
  output logic frame_n_o,
  output logic irdy_n_o,
  output logic done_o
);

  msq_phase_e phase_q, phase_d;
  msq_drive_t drive_q, drive_d;
  logic       claimed_now;
  logic       disconnect;
  logic       xfer_end;

  assign claimed_now = !devsel_n_i;
  assign disconnect  = claimed_now & !stop_n_i;
  assign xfer_end    = claimed_now & (!trdy_n_i | !stop_n_i);
  assign accept_o    = (phase_q == PH_IDLE) & start_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (start_i) phase_d = PH_ADDR;
      PH_ADDR:  phase_d = PH_DATA;
      PH_DATA: begin
        if (expire_i)                 phase_d = PH_DRAIN;
        else if (last_i || disconnect) phase_d = PH_LAST;
      end
      PH_LAST:  if (expire_i || xfer_end) phase_d = PH_IDLE;
      PH_DRAIN: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    drive_d = msq_drive_of(phase_d, (phase_d == PH_IDLE) && (phase_q != PH_IDLE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      drive_q <= '{frame_n: 1'b1, irdy_n: 1'b1, done: 1'b0};
    end else begin
      phase_q <= phase_d;
      drive_q <= drive_d;
    end
  end

  assign frame_n_o = drive_q.frame_n;
  assign irdy_n_o  = drive_q.irdy_n;
  assign done_o    = drive_q.done;

endmodule

// File: rtl/msq_status_reg.sv
module msq_status_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pci_mabort_seq.sv
module pci_mabort_seq #(
  parameter int unsigned TIMEOUT_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic last_i,
  input  logic devsel_n_i,
  input  logic trdy_n_i,
  input  logic stop_n_i,
  input  logic abort_clr_i,
  output logic frame_n_o,
  output logic irdy_n_o,
  output logic abort_o,
  output logic done_o
);

  if (TIMEOUT_CLKS < 2) begin : g_bad_window
    $error("TIMEOUT_CLKS must be at least 2");
  end

  logic accept;
  logic expire;

  msq_claim_timer #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (accept),
    .devsel_n_i (devsel_n_i),
    .expire_o   (expire)
  );

  msq_phase_fsm fsm_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .last_i     (last_i),
    .devsel_n_i (devsel_n_i),
    .trdy_n_i   (trdy_n_i),
    .stop_n_i   (stop_n_i),
    .expire_i   (expire),
    .accept_o   (accept),
    .frame_n_o  (frame_n_o),
    .irdy_n_o   (irdy_n_o),
    .done_o     (done_o)
  );

  msq_status_reg status_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (expire),
    .clr_i  (abort_clr_i),
    .flag_o (abort_o)
  );

endmodule

// File: rtl/pci_mabort_seq_chk.sv
module pci_mabort_seq_chk (
  input logic clk,
  input logic rst,
  input logic abort_clr_i,
  input logic frame_n_o,
  input logic irdy_n_o,
  input logic abort_o,
  input logic done_o
);

  // R2: the address phase has FRAME low with IRDY still released
  a_r2_addr_phase_irdy_high: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n_o) |-> irdy_n_o);

  // R5: IRDY is held low in the cycle FRAME is released
  a_r5_irdy_low_at_frame_release: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_n_o) |-> !irdy_n_o);

  // R11: done coincides with the release of IRDY
  a_r11_done_with_irdy_release: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $rose(irdy_n_o));

  // R11: done lasts a single cycle
  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R12: the flag holds until cleared
  a_r12_abort_sticky: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !abort_clr_i) |=> abort_o);

  // R4: by the time the abort is flagged FRAME is no longer driven
  a_r4_abort_frame_released: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_o) |-> frame_n_o);

endmodule

bind pci_mabort_seq pci_mabort_seq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .abort_clr_i (abort_clr_i),
  .frame_n_o   (frame_n_o),
  .irdy_n_o    (irdy_n_o),
  .abort_o     (abort_o),
  .done_o      (done_o)
);

// File: tb/pci_mabort_seq_tb_top.sv
`timescale 1ns/1ps
module pci_mabort_seq_tb_top;

  localparam int TO = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, last = 1'b0, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, clr = 1'b0;
  logic frame_n, irdy_n, abort, done;

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pci_mabort_seq #(.TIMEOUT_CLKS(TO)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .last_i(last), .devsel_n_i(devsel_n),
    .trdy_n_i(trdy_n), .stop_n_i(stop_n), .abort_clr_i(clr),
    .frame_n_o(frame_n), .irdy_n_o(irdy_n), .abort_o(abort), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Behavioural reference, advanced on each rising edge
  int  m_phase = 0;   // 0 idle, 1 address, 2 data, 3 last, 4 drain
  int  m_seen = 0;
  bit  m_armed = 0;
  bit  m_valid = 0;
  bit  e_frame = 1, e_irdy = 1, e_done = 0, e_abort = 0;

  always @(posedge clk) begin : ref_model
    bit ex;
    int was;
    m_valid = 1;
    if (rst) begin
      m_phase = 0; m_armed = 0; m_seen = 0;
      e_frame = 1; e_irdy = 1; e_done = 0; e_abort = 0;
    end else begin
      ex  = m_armed && devsel_n && (m_seen == TO - 1);
      was = m_phase;
      if (m_armed) begin
        if (!devsel_n || ex) m_armed = 0;
        else m_seen++;
      end
      if (ex) e_abort = 1;
      else if (clr) e_abort = 0;
      case (m_phase)
        0: if (start) begin m_phase = 1; m_armed = 1; m_seen = 0; end
        1: m_phase = 2;
        2: if (ex) m_phase = 4;
           else if (last || (!devsel_n && !stop_n)) m_phase = 3;
        3: if (ex || (!devsel_n && (!trdy_n || !stop_n))) m_phase = 0;
        default: m_phase = 0;
      endcase
      e_done  = (m_phase == 0) && (was != 0);
      e_frame = !(m_phase == 1 || m_phase == 2);
      e_irdy  = !(m_phase == 2 || m_phase == 3 || m_phase == 4);
    end
  end

  always @(negedge clk) begin
    if (m_valid && !finished) begin
      chk("R8 frame_n vs model", frame_n, e_frame);
      chk("R9 irdy_n vs model", irdy_n, e_irdy);
      chk("R11 done vs model", done, e_done);
      chk("R12 abort vs model", abort, e_abort);
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 reset frame_n", frame_n, 1); chk("R1 reset irdy_n", irdy_n, 1);
    chk("R1 reset done", done, 0);       chk("R1 reset abort", abort, 0);
    rst = 1'b0;
    tick();
    chk("R1 post-reset frame_n", frame_n, 1); chk("R1 post-reset irdy_n", irdy_n, 1);

    // Abort with FRAME still low; start while busy ignored
    start = 1'b1; tick();                                  // t0
    start = 1'b0;
    chk("R2 addr frame_n", frame_n, 0); chk("R2 addr irdy_n", irdy_n, 1);
    tick(); chk("R2 data irdy_n", irdy_n, 0);              // t0+1
    tick(); start = 1'b1;                                  // t0+2
    tick(); start = 1'b0;                                  // t0+3
    tick(); chk("R4 no early abort", abort, 0); chk("R5 frame still low", frame_n, 0); // t0+4
    tick(); chk("R5 frame released", frame_n, 1); chk("R5 irdy held", irdy_n, 0);      // t0+5
    chk("R4 abort flagged", abort, 1);
    tick(); chk("R5 irdy released", irdy_n, 1); chk("R11 done abort", done, 1);        // t0+6
    tick(); chk("R11 done one cycle", done, 0); chk("R3 busy start ignored", frame_n, 1);
    chk("R12 abort sticky", abort, 1); clr = 1'b1;         // t0+7
    tick(); clr = 1'b0; chk("R12 abort cleared", abort, 0);

    // Abort after the last data phase has begun
    start = 1'b1; tick(); start = 1'b0;                    // t0
    tick(); last = 1'b1;                                   // t0+1
    tick(); last = 1'b0;                                   // t0+2
    chk("R8 frame up on last", frame_n, 1); chk("R8 irdy held on last", irdy_n, 0);
    tick(); tick();                                        // t0+4
    chk("R6 irdy before detect", irdy_n, 0);
    tick(); chk("R6 irdy released", irdy_n, 1); chk("R6 done", done, 1); chk("R6 abort", abort, 1); // t0+5
    clr = 1'b1;
    tick(); clr = 1'b0; chk("R12 cleared again", abort, 0);

    // Claimed transaction, normal end by TRDY
    start = 1'b1; tick(); start = 1'b0;                    // t0
    tick(); devsel_n = 1'b0;                               // t0+1
    tick(); devsel_n = 1'b1; last = 1'b1;                  // t0+2
    tick(); last = 1'b0;                                   // t0+3
    tick(); tick(); tick(); tick();                        // t0+7
    chk("R7 no abort after claim", abort, 0); chk("R7 irdy still held", irdy_n, 0);
    devsel_n = 1'b0; trdy_n = 1'b0;
    tick(); devsel_n = 1'b1; trdy_n = 1'b1;                // t0+8
    chk("R9 irdy released on trdy", irdy_n, 1); chk("R9 done", done, 1);

    // Target disconnect by STOP, then back-to-back start
    start = 1'b1; tick(); start = 1'b0;                    // t0
    tick(); devsel_n = 1'b0; stop_n = 1'b0;                // t0+1
    tick(); chk("R10 frame up on stop", frame_n, 1); chk("R10 irdy held", irdy_n, 0); // t0+2
    tick(); chk("R9 irdy released on stop", irdy_n, 1); chk("R11 done normal", done, 1); // t0+3
    devsel_n = 1'b1; stop_n = 1'b1; start = 1'b1;
    tick(); start = 1'b0; clr = 1'b1;                      // T0
    tick(); tick(); tick(); tick();                        // T0+4
    chk("R13 full window", abort, 0); chk("R13 frame still low", frame_n, 0);
    tick(); chk("R12 set beats clear", abort, 1); chk("R13 frame released", frame_n, 1); // T0+5
    tick(); chk("R12 clear applies", abort, 0); chk("R11 done back-to-back", done, 1);   // T0+6
    clr = 1'b0;
    tick(); tick();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule